// File: doc/BRIEF.md
# Three-Level Interrupt Status Tree Controller

This block gathers a parameterised number of interrupt input lines, grouped eight to a block, and reduces them to one summary interrupt for a host. Every line passes through a two-flop synchroniser. A per-line detector then latches a pending bit on an edge or on a level, as that line's configuration selects. Pending bits are summarised block by block, the block summaries eight at a time into master bytes, and the master summaries into a root byte. The summary interrupt output is raised while any root bit is set.

The host works through a small synchronous register port with a 4-bit address, write and read strobes, and 8-bit data. It walks the tree from the root, reads a master byte, and writes the block number it wants into a selector register. It can then read that block's latched and live status. A line is configured by writing a byte to a configuration register. A 3-bit field in that byte names the line inside the selected block, and a valid-write flag must be set for the write to take effect. Read data appears one clock after the read strobe and holds until the next read.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every line is in edge mode with both masks set and nothing pending. irq_out is 0, and the root byte and block selector both read 0.
- R2: Address map: 0 root, 1 to 4 master bytes 0 to 3, 5 block selector (read/write), 6 latched status of the selected block, 7 configuration (write only), 8 live status of the selected block. Other addresses, and master bytes beyond the implemented count, read 0. rdata is loaded on the clock edge where rd_en is high.
- R3: Root bit 0 always reads 0, and root bit m+1 is the OR of master byte m. irq_out is high exactly when some latched pending bit is set.
- R4: Line p sits in block p/8 at bit p%8. Bit i of master byte m is set when block m*8+i has any pending bit.
- R5: A configuration write acts only when wdata[7] is 1. wdata[6:4] picks the line within the selected block. The other fields are bit 0 = level mode, bit 1 = mask falling edge / low level, bit 2 = mask rising edge / high level, bit 3 = clear.
- R6: In edge mode, a rising transition of the synchronised input sets pending unless bit 2 is set. A falling transition sets it unless bit 1 is set. A masked edge changes nothing.
- R7: In level mode, pending is set while the input is high and bit 2 is clear, or while it is low and bit 1 is clear. It sets again after a clear for as long as that level lasts.
- R8: A valid write with bit 3 set clears the line's pending bit on that edge, with priority over detection. Writing both masks together with clear (mask-and-acknowledge) leaves the bit at 0.
- R9: The live status shows each line's synchronised level two clocks after the input changes, whatever its mask or pending state.
- R10: With the selector at or above the block count, both status reads return 0 and configuration writes change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Asynchronous interrupt inputs |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Summary interrupt to the host |

## Verification
The hardest case to reach is the order of a clear against detection on the same edge. It shows up in two places: a level that is still active after a clear, and a mask-and-acknowledge while that level holds. To reach it, the bench puts a line in level mode with its input held high, then issues a plain clear and a mask-and-clear one after the other. A read straight after each write shows whether the bit came back. Indexing mistakes are found by writing a configuration under an out-of-range selector whose low bits alias a live block, then reading that block.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int OFS_ROOT   = 0;
  localparam int OFS_MASTER = 1;
  localparam int OFS_BSEL   = 5;
  localparam int OFS_LATCH  = 6;
  localparam int OFS_CFG    = 7;
  localparam int OFS_LIVE   = 8;
  localparam int MAX_MASTERS = 4;

  function automatic int blocks_for(input int lines);
    return (lines + 7) / 8;
  endfunction

  function automatic int masters_for(input int lines);
    int m;
    m = (blocks_for(lines) + 7) / 8;
    return (m > MAX_MASTERS) ? MAX_MASTERS : m;
  endfunction
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic       cfg_we,
  input  logic [3:0] cfg_bits,
  output logic       level_o,
  output logic       pend_o
);
  logic s1, s2, prev;
  logic lvl_mode, mask_fall, mask_rise;
  logic rise_evt, fall_evt, set_evt, clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
    end else begin
      s1 <= raw_in; s2 <= s1; prev <= s2;
    end
  end

  assign rise_evt = s2 & ~prev;
  assign fall_evt = ~s2 & prev;
  assign clr_evt  = cfg_we & cfg_bits[3];
  assign set_evt  = lvl_mode ? ((s2 & ~mask_rise) | (~s2 & ~mask_fall))
                             : ((rise_evt & ~mask_rise) | (fall_evt & ~mask_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_mode <= 1'b0; mask_fall <= 1'b1; mask_rise <= 1'b1;
    end else if (cfg_we) begin
      lvl_mode <= cfg_bits[0]; mask_fall <= cfg_bits[1]; mask_rise <= cfg_bits[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (clr_evt) pend_o <= 1'b0;
    else if (set_evt) pend_o <= 1'b1;
  end

  assign level_o = s2;

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rise && mask_fall && !pend_o) |=> !pend_o);
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && !mask_rise && rise_evt && !clr_evt) |=> pend_o);
  assert_level_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && pend_o && !clr_evt) |=> pend_o);
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !pend_o);
endmodule

// File: rtl/irq_status_tree.sv
module irq_status_tree #(
  parameter int NUM_BLOCKS  = 9,
  parameter int NUM_MASTERS = 2
) (
  input  logic [NUM_BLOCKS*8-1:0] pend_pad,
  output logic [3:0][7:0]         master_bytes,
  output logic [7:0]              root_byte
);
  localparam int SLOTS = NUM_MASTERS * 8;
  logic [SLOTS-1:0] blk_any;

  for (genvar b = 0; b < SLOTS; b++) begin : g_blk
    if (b < NUM_BLOCKS) begin : g_real
      assign blk_any[b] = |pend_pad[b*8 +: 8];
    end else begin : g_void
      assign blk_any[b] = 1'b0;
    end
  end

  for (genvar m = 0; m < 4; m++) begin : g_mst
    if (m < NUM_MASTERS) begin : g_real
      assign master_bytes[m] = blk_any[m*8 +: 8];
      assign root_byte[m+1]  = |blk_any[m*8 +: 8];
    end else begin : g_void
      assign master_bytes[m] = 8'h00;
      assign root_byte[m+1]  = 1'b0;
    end
  end
  assign root_byte[0]   = 1'b0;
  assign root_byte[7:5] = 3'b000;
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 72
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [3:0]           addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 irq_out
);
  localparam int NUM_BLOCKS  = blocks_for(NUM_LINES);
  localparam int NUM_MASTERS = masters_for(NUM_LINES);
  localparam int PAD         = NUM_BLOCKS * 8;

  logic [7:0]     blk_sel;
  logic           sel_ok, cfg_hit;
  logic [PAD-1:0] pend_pad, live_pad;
  logic [3:0][7:0] master_bytes;
  logic [7:0]     root_byte, latch_byte, live_byte, rd_next;

  assign sel_ok  = int'(blk_sel) < NUM_BLOCKS;
  assign cfg_hit = wr_en && (addr == 4'(OFS_CFG)) && wdata[7] && sel_ok;

  for (genvar p = 0; p < PAD; p++) begin : g_line
    if (p < NUM_LINES) begin : g_real
      logic line_we;
      assign line_we = cfg_hit && (blk_sel == 8'(p / 8)) && (wdata[6:4] == 3'(p % 8));
      irq_line_cell u_cell (
        .clk(clk), .rst_n(rst_n), .raw_in(irq_lines[p]),
        .cfg_we(line_we), .cfg_bits(wdata[3:0]),
        .level_o(live_pad[p]), .pend_o(pend_pad[p])
      );
    end else begin : g_void
      assign live_pad[p] = 1'b0;
      assign pend_pad[p] = 1'b0;
    end
  end

  irq_status_tree #(.NUM_BLOCKS(NUM_BLOCKS), .NUM_MASTERS(NUM_MASTERS)) u_tree (
    .pend_pad(pend_pad), .master_bytes(master_bytes), .root_byte(root_byte)
  );

  always_comb begin
    latch_byte = 8'h00;
    live_byte  = 8'h00;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (int'(blk_sel) == b) begin
        latch_byte = pend_pad[b*8 +: 8];
        live_byte  = live_pad[b*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_next = 8'h00;
    case (int'(addr))
      OFS_ROOT:       rd_next = root_byte;
      OFS_MASTER:     rd_next = master_bytes[0];
      OFS_MASTER + 1: rd_next = master_bytes[1];
      OFS_MASTER + 2: rd_next = master_bytes[2];
      OFS_MASTER + 3: rd_next = master_bytes[3];
      OFS_BSEL:       rd_next = blk_sel;
      OFS_LATCH:      rd_next = latch_byte;
      OFS_LIVE:       rd_next = live_byte;
      default:        rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_sel <= 8'h00;
      rdata   <= 8'h00;
    end else begin
      if (wr_en && addr == 4'(OFS_BSEL)) blk_sel <= wdata;
      if (rd_en) rdata <= rd_next;
    end
  end

  assign irq_out = |root_byte;

  assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 4'(OFS_BSEL)) |=> $stable(blk_sel));
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) > OFS_LIVE) |=> rdata == 8'h00);
  assert_irq_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|pend_pad));
  assert_bad_sel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_ok && (addr == 4'(OFS_LATCH) || addr == 4'(OFS_LIVE))) |=> rdata == 8'h00);
endmodule

// File: tb/tb_irq_tree_ctrl.sv
`timescale 1ns/100ps
module tb_irq_tree_ctrl;
  localparam int NL = 72;
  logic clk = 0, rst_n = 0;
  logic [NL-1:0] irq_lines = '0;
  logic [3:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_out;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic arm = 0;
  bit done = 0;

  irq_tree_ctrl #(.NUM_LINES(NL)) dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) arm <= rd_en;

  always @(negedge clk) begin
    if (arm && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = 4'(a); rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s: irq_out=%0b expected=%0b", t, irq_out, e);
    end
  endtask

  function automatic logic [7:0] cfg(input int line_bit, input logic [3:0] f);
    return {1'b1, 3'(line_bit), f};
  endfunction

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          bad++; total++;
          $display("FAIL watchdog: run hung, expected completion");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    tick(3); rst_n = 1; tick(2);
    chk_irq(0, "R1 reset irq");
    rd(0, 8'h00, "R1 reset root");
    rd(5, 8'h00, "R1 reset block select");
    // line 13: block 1 bit 5, edge, falling masked
    wr(5, 8'd1);
    wr(7, cfg(5, 4'b0010));
    irq_lines[13] = 1; tick(3);
    rd(6, 8'h20, "R6 rising edge latched");
    rd(1, 8'h02, "R4 master0 block1");
    rd(0, 8'h02, "R3 root bit1");
    tick(1); chk_irq(1, "R3 irq on pending");
    wr(7, cfg(5, 4'b1010));
    rd(6, 8'h00, "R8 clear pending");
    tick(2);
    rd(6, 8'h00, "R6 edge no reassert while high");
    tick(1); chk_irq(0, "R3 irq after clear");
    irq_lines[13] = 0; tick(3);
    rd(6, 8'h00, "R6 masked falling ignored");
    // line 8: block 1 bit 0, still masked
    rd(8, 8'h00, "R9 live low");
    irq_lines[8] = 1; tick(2);
    rd(8, 8'h01, "R9 live shows masked line");
    rd(6, 8'h00, "R9 masked line not latched");
    wr(7, 8'h01);
    tick(3);
    rd(6, 8'h00, "R5 write without valid flag ignored");
    wr(7, cfg(0, 4'b0011));
    tick(2);
    rd(6, 8'h01, "R7 level high latched");
    wr(7, cfg(0, 4'b1011));
    rd(6, 8'h01, "R7 level reasserts after clear");
    wr(7, cfg(0, 4'b1111));
    rd(6, 8'h00, "R8 mask and acknowledge");
    tick(1); chk_irq(0, "R8 irq low after ack");
    // line 20: block 2 bit 4, level low
    wr(5, 8'd2);
    wr(7, cfg(4, 4'b0101));
    tick(2);
    rd(6, 8'h10, "R7 level low latched");
    rd(1, 8'h04, "R4 master0 block2");
    rd(0, 8'h02, "R3 root master0");
    // line 70: block 8 bit 6, master 1
    wr(5, 8'd8);
    wr(7, cfg(6, 4'b0010));
    irq_lines[70] = 1; tick(3);
    rd(2, 8'h01, "R4 master1 block8");
    rd(0, 8'h06, "R3 root two masters");
    wr(7, cfg(6, 4'b1100));
    rd(6, 8'h00, "R8 clear line70");
    irq_lines[70] = 0; tick(3);
    rd(6, 8'h40, "R6 falling edge latched");
    rd(5, 8'h08, "R2 block select readback");
    rd(3, 8'h00, "R2 unimplemented master");
    rd(12, 8'h00, "R2 unused address");
    // out-of-range select, aliasing block 1 in low bits
    wr(5, 8'd9);
    rd(6, 8'h00, "R10 latched out of range");
    rd(8, 8'h00, "R10 live out of range");
    wr(7, cfg(0, 4'b0001));
    tick(3);
    wr(5, 8'd1);
    rd(6, 8'h00, "R10 config write ignored");
    rd(8, 8'h01, "R9 live block1 line8");
    tick(3);
    if (exp_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule